// File: doc/BRIEF.md
# Register-Mapped Hardware Mutex

This block is a single binary lock that threads, whether software running on a processor or hardware engines, reach through three word offsets on a simple synchronous register bus. To claim the lock, a thread writes its own non-zero identifier to the claim offset. A small two-state controller takes the claim only if nobody holds the lock. If the lock is held, the controller silently discards the claim. The thread then reads the holder offset and compares the value with its own identifier. A match means the thread now holds the lock.

The holder gives the lock back by writing its identifier to the give-back offset. A give-back carrying any other identifier changes nothing, so a thread that does not hold the lock cannot free it. Identifier 0 is reserved and means "unheld". Only one bus master drives the registers in any cycle. Mutual exclusion therefore rests on this conditional acceptance of a plain write, and no atomic processor instruction is needed.

Top module: `hw_mutex_regs`

## Requirements
- R1: After reset the holder offset (2) reads 0, meaning the lock is unheld.
- R2: A write of a non-zero identifier to the claim offset (0) while the lock is unheld makes that identifier the holder on the same clock edge, so a read issued in the next cycle returns it.
- R3: A claim written while the lock is held leaves the holder unchanged.
- R4: A write to the give-back offset (1) whose identifier equals the current holder makes the lock unheld, and the holder offset then reads 0.
- R5: A give-back whose identifier differs from the current holder has no effect.
- R6: A claim carrying identifier 0 has no effect.
- R7: The identifier is taken from the low ID_W bits of the write data. The bits above them are ignored.
- R8: Reads of offsets 0, 1 and 3 return 0. A read of offset 2 returns the holder zero-extended to DATA_W bits.
- R9: Writes to offsets 2 and 3 have no effect on the lock.
- R10: Read data is registered. It presents the value addressed by a read on the clock edge that samples that read, and it is 0 after any edge with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | DATA_W | Write data, identifier in low ID_W bits |
| bus_rdata | output | DATA_W | Registered read data |

## Verification
On every cycle, the embedded properties check each per-cycle rule of the controller:
- a claim on an unheld lock loads the identifier;
- claims on a held lock, identifier-0 claims, mismatched give-backs and idle cycles all leave the holder stable;
- a matching give-back clears the holder;
- the state encoding always agrees with the holder value;
- reads of non-holder offsets return zero.

Only the bench's scenarios can show the behaviour seen from the bus across whole sequences. The bench sweeps every pair of competing identifiers through claim, rival claim and two give-backs. It also covers the ignored upper data bits, writes to read-only offsets, and the one-cycle read-after-claim timing.

// File: rtl/hwmx_pkg.sv
package hwmx_pkg;

   localparam int unsigned OFS_CLAIM  = 0;
   localparam int unsigned OFS_GIVE   = 1;
   localparam int unsigned OFS_HOLDER = 2;

   typedef enum logic {
      LK_FREE = 1'b0,
      LK_HELD = 1'b1
   } lock_state_e;

endpackage

// File: rtl/hwmx_decode.sv
module hwmx_decode #(
   parameter int unsigned ADDR_W = 2
) (
   input  logic              wr,
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr,
   output logic              claim_stb,
   output logic              give_stb,
   output logic              holder_rd
);
   import hwmx_pkg::*;

   localparam logic [ADDR_W-1:0] A_CLAIM  = ADDR_W'(OFS_CLAIM);
   localparam logic [ADDR_W-1:0] A_GIVE   = ADDR_W'(OFS_GIVE);
   localparam logic [ADDR_W-1:0] A_HOLDER = ADDR_W'(OFS_HOLDER);

   initial begin
      assert (ADDR_W >= 2)
         else $error("hwmx_decode: ADDR_W must cover three offsets");
   end

   assign claim_stb = wr && (addr == A_CLAIM);
   assign give_stb  = wr && (addr == A_GIVE);
   assign holder_rd = rd && (addr == A_HOLDER);

endmodule

// File: rtl/hwmx_lock.sv
module hwmx_lock #(
   parameter int unsigned ID_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            claim_stb,
   input  logic            give_stb,
   input  logic [ID_W-1:0] id,
   output logic [ID_W-1:0] holder
);
   import hwmx_pkg::*;

   localparam logic [ID_W-1:0] NO_ID = '0;

   lock_state_e state;

   initial begin
      assert (ID_W >= 1)
         else $error("hwmx_lock: ID_W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= LK_FREE;
         holder <= NO_ID;
      end else begin
         case (state)
            LK_FREE: begin
               if (claim_stb && (id != NO_ID)) begin
                  holder <= id;
                  state  <= LK_HELD;
               end
            end
            LK_HELD: begin
               if (give_stb && (id == holder)) begin
                  holder <= NO_ID;
                  state  <= LK_FREE;
               end
            end
            default: begin
               holder <= NO_ID;
               state  <= LK_FREE;
            end
         endcase
      end
   end

   // R2: a valid claim on an unheld lock loads the claimant
   p_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_stb && holder == NO_ID && id != NO_ID) |=> (holder == $past(id)));

   // R3: claims against a held lock change nothing
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_stb && holder != NO_ID) |=> $stable(holder));

   // R4: matching give-back frees the lock
   p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (give_stb && holder != NO_ID && id == holder) |=> (holder == NO_ID));

   // R5: mismatched give-back ignored
   p_badgive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (give_stb && id != holder) |=> $stable(holder));

   // R6: identifier 0 never claims
   p_zero_claim_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_stb && id == NO_ID) |=> $stable(holder));

   // R9: with no claim or give-back strobe the holder stays put
   p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!claim_stb && !give_stb) |=> $stable(holder));

   // R9: decoder never raises both strobes
   p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({claim_stb, give_stb}));

   // R1: state encoding agrees with holder value
   p_state_sync_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == LK_HELD) == (holder != NO_ID)));

endmodule

// File: rtl/hwmx_rdport.sv
module hwmx_rdport #(
   parameter int unsigned ID_W     = 4,
   parameter int unsigned DATA_W   = 32,
   parameter bit          READ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              holder_rd,
   input  logic [ID_W-1:0]   holder,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] rd_value;

   assign rd_value = holder_rd ? DATA_W'(holder) : '0;

   generate
      if (READ_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) rdata <= '0;
            else        rdata <= rd_value;
         end
      end else begin : g_comb
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst_n;
         assign rdata = rd_value;
      end
   endgenerate

endmodule

// File: rtl/hw_mutex_regs.sv
module hw_mutex_regs #(
   parameter int unsigned ID_W     = 4,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ADDR_W   = 2,
   parameter bit          READ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata
);
   import hwmx_pkg::*;

   localparam logic [ADDR_W-1:0] A_HOLDER = ADDR_W'(OFS_HOLDER);

   logic            claim_stb;
   logic            give_stb;
   logic            holder_rd;
   logic [ID_W-1:0] wr_id;
   logic [ID_W-1:0] holder;

   initial begin
      assert (ID_W >= 1 && ID_W <= DATA_W)
         else $error("hw_mutex_regs: ID_W must lie in 1..DATA_W");
   end

   assign wr_id = bus_wdata[ID_W-1:0];

   generate
      if (DATA_W > ID_W) begin : g_hi
         logic unused_hi;
         assign unused_hi = ^bus_wdata[DATA_W-1:ID_W];
      end
   endgenerate

   hwmx_decode #(.ADDR_W(ADDR_W)) u_decode (
      .wr        (bus_wr),
      .rd        (bus_rd),
      .addr      (bus_addr),
      .claim_stb (claim_stb),
      .give_stb  (give_stb),
      .holder_rd (holder_rd)
   );

   hwmx_lock #(.ID_W(ID_W)) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .claim_stb (claim_stb),
      .give_stb  (give_stb),
      .id        (wr_id),
      .holder    (holder)
   );

   hwmx_rdport #(.ID_W(ID_W), .DATA_W(DATA_W), .READ_REG(READ_REG)) u_rdport (
      .clk       (clk),
      .rst_n     (rst_n),
      .holder_rd (holder_rd),
      .holder    (holder),
      .rdata     (bus_rdata)
   );

   generate
      if (READ_REG) begin : g_rd_chk
         // R8: non-holder offsets read as zero
         p_rdzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && bus_addr != A_HOLDER) |=> (bus_rdata == '0));
         // R10: idle cycles leave read data at zero
         p_rdidle_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (!bus_rd) |=> (bus_rdata == '0));
      end
   endgenerate

endmodule

// File: tb/hw_mutex_regs_bench.sv
`timescale 1ns/1ps
module hw_mutex_regs_bench;
   localparam int ID_W   = 3;
   localparam int DATA_W = 8;
   localparam int ADDR_W = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0;
   logic              bus_rd = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;

   int checks = 0;
   int fails  = 0;
   int model  = 0;

   always #2.5 clk = ~clk;

   hw_mutex_regs #(.ID_W(ID_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .READ_REG(1'b1))
   u_hw_mutex_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic bus_write(input int a, input int d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = DATA_W'(d);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   // issues a read in the current cycle, returns data captured at that edge
   task automatic bus_read(input int a, output int v);
      bus_rd = 1'b1; bus_addr = ADDR_W'(a);
      @(negedge clk);
      bus_rd = 1'b0;
      v = int'(bus_rdata);
   endtask

   task automatic claim(input int d);
      int id;
      id = d % (1 << ID_W);
      bus_write(0, d);
      if (model == 0 && id != 0) model = id;
   endtask

   task automatic give(input int d);
      int id;
      id = d % (1 << ID_W);
      bus_write(1, d);
      if (model != 0 && id == model) model = 0;
   endtask

   initial begin
      int v;
      repeat (4) @(negedge clk);
      // R10: read data is zero with no read pending
      check("R10 idle rdata in reset", int'(bus_rdata), 0);
      rst_n = 1'b1;
      @(negedge clk);
      bus_read(2, v);
      check("R1 holder after reset", v, 0);

      // pairwise sweep over all identifiers
      for (int a = 0; a < (1 << ID_W); a++) begin
         for (int b = 0; b < (1 << ID_W); b++) begin
            claim(a);
            bus_read(2, v);
            check(a == 0 ? "R6 zero claim" : "R2 claim free lock", v, model);
            claim(b);
            bus_read(2, v);
            check(a == 0 ? "R2 claim after zero" : "R3 claim held lock", v, model);
            give(b);
            bus_read(2, v);
            check((b == a && a != 0) ? "R4 give-back match" : "R5 give-back other", v, model);
            give(a);
            bus_read(2, v);
            check("R4 R5 final give-back", v, model);
            if (model != 0) give(model);
         end
      end

      // R7: upper data bits ignored
      claim(8'hF5);
      bus_read(2, v);
      check("R7 claim upper bits", v, 5);
      give(8'h25);
      bus_read(2, v);
      check("R7 give-back upper bits", v, 0);
      claim(8'h08);
      bus_read(2, v);
      check("R7 upper-only claim is id 0", v, 0);

      // R8: read map while held
      claim(3);
      bus_read(0, v); check("R8 read claim offset", v, 0);
      bus_read(1, v); check("R8 read give offset", v, 0);
      bus_read(3, v); check("R8 read spare offset", v, 0);
      bus_read(2, v); check("R8 read holder offset", v, 3);
      @(negedge clk);
      check("R10 rdata cleared after idle edge", int'(bus_rdata), 0);

      // R9: writes to read-only and spare offsets
      bus_write(2, 6);
      bus_write(3, 6);
      bus_read(2, v); check("R9 held lock after offset 2/3 writes", v, 3);
      give(3);
      bus_write(2, 4);
      bus_write(3, 4);
      bus_read(2, v); check("R9 free lock after offset 2/3 writes", v, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual still running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule